// File: doc/BRIEF.md
# Memory Map Decoder with Wait-State Generator

This block sits between a processor with an 8-bit data bus and 20-bit addresses and its memory devices. It decodes each bus cycle into one of two regions. The top 32K, from F8000H to FFFFFH, holds eight 4K x 8 EPROMs, and each EPROM has its own active-low chip select. The bottom 512K, from 00000H to 7FFFFH, is one SRAM region with a single active-low select. Every select is qualified by the memory/IO qualifier and by the read and write strobes. The gap from 80000H to F7FFFH and all I/O cycles decode to nothing.

The EPROM region contains the processor's reset location FFFF0H. EPROM access time plus decode delay is longer than the bus allows at full speed. For that reason the block pulls READY low during EPROM reads for a configurable number of clocks, and then raises it again. SRAM cycles run without wait states. The wait counter runs on the processor clock. It returns to idle on a synchronous reset and whenever both strobes are inactive.

Top module: `memmap_wait_decoder`

## Requirements
- R1: A memory cycle (io_sel = 0) with rd_n = 0 or wr_n = 0 and addr[19] = 0 (00000H-7FFFFH) drives ram_cs_n low. Otherwise ram_cs_n is high.
- R2: A memory read (io_sel = 0, rd_n = 0) with addr[19:15] all ones drives rom_cs_n[addr[14:12]] low and leaves the other seven high. Index 0 covers F8000H-F8FFFH and index 7 covers FF000H-FFFFFH.
- R3: A memory read of the reset location FFFF0H drives rom_cs_n[7] low.
- R4: Memory cycles in 80000H-F7FFFH assert no select.
- R5: I/O cycles (io_sel = 1) assert no select at any address.
- R6: With both strobes high, every select is high. A write (rd_n = 1, wr_n = 0) into the EPROM region asserts no EPROM select.
- R7: At most one of the nine selects is low in any cycle.
- R8: During an EPROM read, ready is low from the cycle the read starts until WAIT_CYCLES (default 1) rising clock edges have passed with the read held. After that it stays high for as long as the strobes stay active.
- R9: ready is high during SRAM cycles, I/O cycles and idle cycles.
- R10: While rst = 1, ready is high. After a reset, or after any cycle in which both strobes are high, the next EPROM read again waits the full WAIT_CYCLES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 20 | Bus address |
| io_sel | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rom_cs_n | output | 8 | EPROM chip selects, active low, one per 4K device |
| ram_cs_n | output | 1 | SRAM region select, active low |
| ready | output | 1 | Bus ready; low inserts a wait state |

## Verification
The only internal state is the wait count. If that count is wrong, ready shows it at the ports in the same cycle as the EPROM read. A count that fails to clear makes a later read skip its wait state. A count that fails to stop holds ready low past WAIT_CYCLES. The bench compares ready against its own model every clock, so such a fault is caught within one cycle. It also exercises back-to-back reads without a release, reset in the middle of a read, and release in the middle of a wait. The select decode is purely combinational, so a decode error shows in the same cycle as the address that triggers it.

// File: rtl/memmap_wait_decoder.sv
module memmap_wait_decoder #(
  parameter int ADDR_W      = 20,
  parameter int DEV_AW      = 12,
  parameter int ROM_DEVS    = 8,
  parameter int WAIT_CYCLES = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                io_sel,
  input  logic                rd_n,
  input  logic                wr_n,
  output logic [ROM_DEVS-1:0] rom_cs_n,
  output logic                ram_cs_n,
  output logic                ready
);
  localparam int SEL_W = $clog2(ROM_DEVS);
  localparam int TAG_W = ADDR_W - DEV_AW - SEL_W;
  localparam int CNT_W = $clog2(WAIT_CYCLES + 2);
  localparam logic [CNT_W-1:0] WAIT_LIM = CNT_W'(WAIT_CYCLES);

  logic             strobe_on;
  logic             top_hit;
  logic             rom_en;
  logic [SEL_W-1:0] rom_idx;
  logic [CNT_W-1:0] waited;

  assign strobe_on = ~rd_n | ~wr_n;
  assign top_hit   = &addr[ADDR_W-1 -: TAG_W];
  assign rom_en    = top_hit & ~io_sel & ~rd_n;
  assign rom_idx   = addr[DEV_AW +: SEL_W];
  assign ram_cs_n  = ~(~io_sel & ~addr[ADDR_W-1] & strobe_on);

  for (genvar g = 0; g < ROM_DEVS; g++) begin : g_rom_sel
    assign rom_cs_n[g] = ~(rom_en & (rom_idx == SEL_W'(g)));
  end

  always_ff @(posedge clk) begin
    if (rst || !strobe_on)
      waited <= '0;
    else if (rom_en && waited < WAIT_LIM)
      waited <= waited + 1'b1;
  end

  assign ready = rst | ~(rom_en & (waited < WAIT_LIM));

  // R7
  one_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~{rom_cs_n, ram_cs_n}));

  // R5
  io_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    io_sel |-> (&rom_cs_n && ram_cs_n));

  // R9
  ram_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_cs_n |-> ready);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_n && wr_n) |-> (&rom_cs_n && ram_cs_n && ready));

  // R10
  if (WAIT_CYCLES > 0) begin : g_wait_chk
    // R8
    first_wait_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(rd_n) && $past(wr_n) && !(&rom_cs_n)) |-> !ready);
  end
endmodule

// File: tb/memmap_wait_decoder_tb.sv
module memmap_wait_decoder_tb;
  localparam int WAITS = 1;

  logic        clk = 0;
  logic        rst = 1;
  logic [19:0] addr = '0;
  logic        io_sel = 0;
  logic        rd_n = 1;
  logic        wr_n = 1;
  logic [7:0]  rom_cs_n;
  logic        ram_cs_n;
  logic        ready;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    elapsed = 0;
  string tag = "R10";
  bit    done = 0;

  always #2 clk = ~clk;

  memmap_wait_decoder #(.WAIT_CYCLES(WAITS)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .io_sel(io_sel),
    .rd_n(rd_n), .wr_n(wr_n), .rom_cs_n(rom_cs_n),
    .ram_cs_n(ram_cs_n), .ready(ready));

  function automatic bit rom_read();
    return !io_sel && !rd_n && int'(addr) >= 'hF8000;
  endfunction

  always @(posedge clk) begin
    if (rst || (rd_n && wr_n)) elapsed = 0;
    else if (rom_read() && elapsed < WAITS) elapsed = elapsed + 1;
  end

  always @(negedge clk) begin
    if (!done) begin
      logic [7:0] exp_rom;
      logic       exp_ram;
      logic       exp_rdy;
      exp_rom = 8'hFF;
      if (rom_read()) exp_rom[(int'(addr) - 'hF8000) / 4096] = 1'b0;
      exp_ram = !(!io_sel && (!rd_n || !wr_n) && int'(addr) < 'h80000);
      exp_rdy = rst || !(rom_read() && elapsed < WAITS);
      n_cmp++;
      if (rom_cs_n !== exp_rom) begin
        n_bad++;
        $display("FAIL %s rom_cs_n addr=%h got=%b exp=%b", tag, addr, rom_cs_n, exp_rom);
      end
      n_cmp++;
      if (ram_cs_n !== exp_ram) begin
        n_bad++;
        $display("FAIL %s ram_cs_n addr=%h got=%b exp=%b", tag, addr, ram_cs_n, exp_ram);
      end
      n_cmp++;
      if (ready !== exp_rdy) begin
        n_bad++;
        $display("FAIL %s ready addr=%h got=%b exp=%b", tag, addr, ready, exp_rdy);
      end
      n_cmp++;
      if ($countones(~{rom_cs_n, ram_cs_n}) > 1) begin
        n_bad++;
        $display("FAIL R7 selects=%b got=%0d low exp<=1", {rom_cs_n, ram_cs_n},
                 $countones(~{rom_cs_n, ram_cs_n}));
      end
    end
  end

  task automatic cyc(input logic [19:0] a, input logic io, input logic r, input logic w, input int n);
    @(posedge clk); #1;
    addr = a; io_sel = io; rd_n = r; wr_n = w;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic idle();
    cyc(20'h00000, 0, 1, 1, 1);
  endtask

  initial begin
    tag = "R10";
    repeat (3) @(posedge clk);
    cyc(20'hFFFF0, 0, 0, 1, 2);
    #1 rst = 0;
    idle();
    tag = "R1";
    cyc(20'h00000, 0, 0, 1, 2); idle();
    cyc(20'h7FFFF, 0, 0, 1, 2); idle();
    cyc(20'h12345, 0, 1, 0, 2); idle();
    tag = "R2";
    for (int d = 0; d < 8; d++) begin
      cyc(20'hF8000 + 20'(d * 4096), 0, 0, 1, 4); idle();
      cyc(20'hF8FFF + 20'(d * 4096), 0, 0, 1, 3); idle();
    end
    tag = "R3";
    cyc(20'hFFFF0, 0, 0, 1, 4); idle();
    tag = "R4";
    cyc(20'h80000, 0, 0, 1, 2); idle();
    cyc(20'hF7FFF, 0, 0, 1, 2); idle();
    cyc(20'hC0000, 0, 1, 0, 2); idle();
    tag = "R5";
    cyc(20'hF8000, 1, 0, 1, 2); idle();
    cyc(20'h00100, 1, 1, 0, 2); idle();
    tag = "R6";
    cyc(20'hFC000, 0, 1, 0, 3);
    cyc(20'hFC000, 0, 1, 1, 2);
    tag = "R8";
    cyc(20'h01000, 0, 0, 1, 2);
    cyc(20'hFA000, 0, 0, 1, 3);
    cyc(20'hFB000, 0, 0, 1, 2); idle();
    tag = "R9";
    cyc(20'h40000, 0, 0, 1, 3); idle();
    tag = "R10";
    cyc(20'hFE000, 0, 0, 1, 1);
    cyc(20'hFE000, 0, 1, 1, 1);
    cyc(20'hFE000, 0, 0, 1, 3);
    @(posedge clk); #1 rst = 1;
    @(posedge clk); #1 rst = 0;
    repeat (3) @(posedge clk);
    idle();
    @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule